// File: doc/BRIEF.md
# Clock-Chip Interrupt Flag Generator

This block raises interrupt requests in the manner of a legacy real-time-clock chip. An external base tick arrives 64 times per second, and the block samples it. On each such tick it evaluates three independently enabled causes against the current hours, minutes and seconds, which a separate timekeeper supplies:

- **Update:** fires once each time the seconds value changes.
- **Alarm:** fires when the current time equals a programmed time.
- **Periodic:** fires once every programmed number of base ticks.

The causes are collected in a sticky status byte. A second byte next to it carries an interrupt count. Whenever a tick produces a cause, the block emits a one-cycle interrupt pulse.

Software programs three things through a small write port: the enable bits, the alarm time and a rate exponent. If the tick source had to skip ticks, it reports how many were missed together with the next tick. The periodic counter absorbs those missed ticks so that the periodic rate does not drift, and a lost-tick pulse is raised. When every enable is clear, the block tells the tick source to stop.

Top module: `rtc_irq_top`

## Requirements
- R1: After reset, `status` is 0, `irq_pulse`, `lost_pulse` and `tick_src_en` are 0, and all enables, alarm fields and the rate exponent are 0.
- R2: Configuration writes use the following addresses:
  - `cfg_addr` 0 writes the enables: bit0 = update, bit1 = alarm, bit2 = periodic.
  - Addresses 1, 2 and 3 write the alarm seconds, minutes and hours.
  - Address 4 writes the rate exponent in bits [2:0].
  - `tick_src_en` is high from the cycle after a write exactly when at least one enable bit is set.
  - A tick with no enable set produces no flag and no pulse.
- R3: With update enabled, a tick whose `cur_sec` differs from the `cur_sec` seen on the previous tick sets the update flag, which is status bit 4. A tick with an unchanged `cur_sec` does not set it.
- R4: With alarm enabled, a tick on which `cur_sec` has changed and hours, minutes and seconds all equal the alarm fields sets the alarm flag, which is status bit 5. A further tick at the same time does not set it again.
- R5: With periodic enabled, a counter advances by one per tick. When it reaches the limit, the periodic flag (status bit 6) is set and the counter returns to 0. The limit depends on the rate exponent e:
  - For e from 1 to 6, the limit is 64 >> e, i.e. 64 divided by a rate of 2^e Hz.
  - For e = 0, the limit is 32.
  - For e of 7, the limit is 1.
  - While periodic is disabled, the counter is held at 0.
- R6: A tick that comes with a nonzero `missed_ticks` adds that number to the periodic counter on top of its own step. It also gives a one-cycle `lost_pulse` in the following cycle.
- R7: Status bit 7 (the summary flag) is set exactly when any of bits 6:4 is set, and `status[15:8]` is then 1 (otherwise 0). Bits 3:0 are always 0.
- R8: Status flags stay set until a cycle with `stat_rd` high, and are 0 after it. A cause arising on the same edge as a read is kept.
- R9: `irq_pulse` is high for the single cycle after a tick that produces any cause, and is low otherwise.
- R10: A cause whose enable bit is 0 never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse per 64 Hz base tick |
| missed_ticks | input | MW | Ticks skipped before this tick |
| cur_hr | input | TW | Current hours |
| cur_min | input | TW | Current minutes |
| cur_sec | input | TW | Current seconds |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | TW | Configuration write data |
| stat_rd | input | 1 | Status read; acknowledges flags |
| status | output | 16 | {count byte, flag byte} |
| irq_pulse | output | 1 | One-cycle interrupt request |
| lost_pulse | output | 1 | One-cycle missed-tick indication |
| tick_src_en | output | 1 | Request to keep the tick source running |

## Verification
Every result is due one clock edge after its stimulus, because a single register stage sits between the inputs and the outputs:
- The tick sampled at a rising edge sets the flags, `irq_pulse` and `lost_pulse` at that same edge.
- A configuration write changes `tick_src_en` and the comparison values at its edge.
- A read clears the flags at its edge.

The bench therefore drives inputs on the falling edge and samples the outputs on the following falling edge, which lies half a period after the edge that updated them. It reads the status value before raising `stat_rd`.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  localparam int BASE_RATE_HZ = 64;
  localparam int BASE_LOG2    = $clog2(BASE_RATE_HZ);
  localparam int RATE_SEL_W   = 3;
  localparam int LIMIT_W      = BASE_LOG2 + 1;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } cause_t;

  typedef enum logic [2:0] {
    CA_ENABLE  = 3'd0,
    CA_ALM_SEC = 3'd1,
    CA_ALM_MIN = 3'd2,
    CA_ALM_HR  = 3'd3,
    CA_RATE    = 3'd4
  } cfg_addr_e;

  // Ticks per periodic event for a rate of 2^sel Hz; 0 maps to 2 Hz, large values saturate at 1.
  function automatic logic [LIMIT_W-1:0] period_limit(input logic [RATE_SEL_W-1:0] sel);
    int unsigned s;
    s = (sel == '0) ? 1 : int'(sel);
    if (s > BASE_LOG2) s = BASE_LOG2;
    return LIMIT_W'(BASE_RATE_HZ >> s);
  endfunction

  function automatic logic [7:0] flag_byte(input cause_t c);
    return {(|c), c.per, c.alm, c.upd, 4'b0000};
  endfunction

  function automatic logic [7:0] count_byte(input cause_t c);
    return {7'b0, (|c)};
  endfunction
endpackage

// File: rtl/rtc_irq_cfg.sv
`timescale 1ns/1ps
module rtc_irq_cfg
  import rtc_irq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [2:0]            addr,
  input  logic [TW-1:0]         wdata,
  output cause_t                en,
  output logic [TW-1:0]         alm_sec,
  output logic [TW-1:0]         alm_min,
  output logic [TW-1:0]         alm_hr,
  output logic [RATE_SEL_W-1:0] rate_sel
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[TW-1:RATE_SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= '0;
      alm_sec  <= '0;
      alm_min  <= '0;
      alm_hr   <= '0;
      rate_sel <= '0;
    end else if (we) begin
      case (cfg_addr_e'(addr))
        CA_ENABLE:  en       <= cause_t'(wdata[2:0]);
        CA_ALM_SEC: alm_sec  <= wdata;
        CA_ALM_MIN: alm_min  <= wdata;
        CA_ALM_HR:  alm_hr   <= wdata;
        CA_RATE:    rate_sel <= wdata[RATE_SEL_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_irq_eval.sv
`timescale 1ns/1ps
module rtc_irq_eval
  import rtc_irq_pkg::*;
#(
  parameter int TW = 8,
  parameter int MW = 4,
  parameter int CW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [MW-1:0]      missed,
  input  logic [TW-1:0]      cur_hr,
  input  logic [TW-1:0]      cur_min,
  input  logic [TW-1:0]      cur_sec,
  input  cause_t             en,
  input  logic [TW-1:0]      alm_hr,
  input  logic [TW-1:0]      alm_min,
  input  logic [TW-1:0]      alm_sec,
  input  logic [LIMIT_W-1:0] limit,
  output cause_t             hits
);
  logic [TW-1:0] prev_sec_q;
  logic [CW-1:0] per_cnt_q;
  logic [CW-1:0] per_sum;
  logic          sec_changed;
  logic          time_match;

  function automatic logic same_time(input logic [TW-1:0] h, m, s, ah, am, as_);
    return (h == ah) && (m == am) && (s == as_);
  endfunction

  assign sec_changed = (cur_sec != prev_sec_q);
  assign time_match  = same_time(cur_hr, cur_min, cur_sec, alm_hr, alm_min, alm_sec);
  assign per_sum     = per_cnt_q + CW'(missed) + CW'(1);

  always_comb begin
    hits     = '0;
    hits.upd = tick && en.upd && sec_changed;
    hits.alm = tick && en.alm && sec_changed && time_match;
    hits.per = tick && en.per && (per_sum >= CW'(limit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sec_q <= '0;
      per_cnt_q  <= '0;
    end else begin
      if (tick) prev_sec_q <= cur_sec;
      if (!en.per)       per_cnt_q <= '0;
      else if (tick)     per_cnt_q <= hits.per ? '0 : per_sum;
    end
  end
endmodule

// File: rtl/rtc_irq_status.sv
`timescale 1ns/1ps
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   missed_nz,
  input  cause_t hits,
  input  logic   rd,
  output cause_t flags,
  output logic   irq,
  output logic   lost
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
      lost  <= 1'b0;
    end else begin
      flags <= (rd ? cause_t'('0) : flags) | hits;
      irq   <= |hits;
      lost  <= tick && missed_nz;
    end
  end
endmodule

// File: rtl/rtc_irq_top.sv
`timescale 1ns/1ps
module rtc_irq_top
  import rtc_irq_pkg::*;
#(
  parameter int TW = 8,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic [MW-1:0] missed_ticks,
  input  logic [TW-1:0] cur_hr,
  input  logic [TW-1:0] cur_min,
  input  logic [TW-1:0] cur_sec,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          stat_rd,
  output logic [15:0]   status,
  output logic          irq_pulse,
  output logic          lost_pulse,
  output logic          tick_src_en
);
  localparam int CW = $clog2((2 ** LIMIT_W) + (2 ** MW)) + 1;

  cause_t                en;
  cause_t                hits;
  cause_t                flags;
  logic [TW-1:0]         alm_sec, alm_min, alm_hr;
  logic [RATE_SEL_W-1:0] rate_sel;
  logic [LIMIT_W-1:0]    limit;
  logic                  hit_upd, hit_alm, hit_per;

  rtc_irq_cfg #(.TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr), .rate_sel(rate_sel)
  );

  assign limit = period_limit(rate_sel);

  rtc_irq_eval #(.TW(TW), .MW(MW), .CW(CW)) u_eval (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .missed(missed_ticks),
    .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec), .en(en),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec), .limit(limit), .hits(hits)
  );

  assign hit_upd = hits.upd;
  assign hit_alm = hits.alm;
  assign hit_per = hits.per;

  rtc_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .missed_nz(|missed_ticks),
    .hits(hits), .rd(stat_rd), .flags(flags), .irq(irq_pulse), .lost(lost_pulse)
  );

  assign status      = {count_byte(flags), flag_byte(flags)};
  assign tick_src_en = |en;
endmodule

// File: rtl/rtc_irq_chk.sv
`timescale 1ns/1ps
module rtc_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        base_tick,
  input logic        stat_rd,
  input logic [15:0] status,
  input logic        irq_pulse,
  input logic        lost_pulse,
  input logic        tick_src_en,
  input logic        hit_upd,
  input logic        hit_alm,
  input logic        hit_per
);
  // R7
  summary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == (|status[6:4])) && (status[15:8] == {7'b0, status[7]}) && (status[3:0] == 4'b0));
  // R9
  irq_has_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> status[7]);
  // R9
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(base_tick));
  // R3
  upd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_upd |=> status[4]);
  // R4
  alm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_alm |=> status[5]);
  // R5
  per_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_per |=> status[6]);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (($past(status[6:4]) & ~status[6:4]) == 3'b000));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !base_tick) |=> (status[7:0] == 8'h00));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_src_en && base_tick) |=> !irq_pulse);
  // R6
  lost_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> $past(base_tick));
endmodule

bind rtc_irq_top rtc_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .stat_rd(stat_rd), .status(status),
  .irq_pulse(irq_pulse), .lost_pulse(lost_pulse), .tick_src_en(tick_src_en),
  .hit_upd(hit_upd), .hit_alm(hit_alm), .hit_per(hit_per)
);

// File: tb/sim_rtc_irq_top.sv
`timescale 1ns/1ps
module sim_rtc_irq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic [3:0]  missed_ticks = '0;
  logic [7:0]  cur_hr = '0, cur_min = '0, cur_sec = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        stat_rd = 1'b0;
  logic [15:0] status;
  logic        irq_pulse, lost_pulse, tick_src_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rtc_irq_top u0 (.*);

  // {sec, missed, lost expected, flag byte expected}; enables update+periodic, limit 2
  localparam logic [23:0] VEC [8] = '{
    {8'd0, 4'd0, 4'd0, 8'h00},
    {8'd0, 4'd0, 4'd0, 8'hC0},
    {8'd1, 4'd0, 4'd0, 8'h90},
    {8'd1, 4'd1, 4'd1, 8'hC0},
    {8'd2, 4'd0, 4'd0, 8'h90},
    {8'd3, 4'd0, 4'd0, 8'hD0},
    {8'd3, 4'd0, 4'd0, 8'h00},
    {8'd3, 4'd3, 4'd1, 8'hC0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input logic [7:0] h, m, s, input logic [3:0] miss);
    cur_hr = h; cur_min = m; cur_sec = s; missed_ticks = miss; base_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    base_tick = 1'b0; missed_ticks = '0;
  endtask

  task automatic rd(output logic [15:0] v);
    v = status; stat_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    int pulses;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 status in reset", status, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 16'h0);
    chk("R1 irq", irq_pulse, 0);
    chk("R1 src_en", tick_src_en, 0);

    // R2 tick with nothing enabled
    tick(8'd0, 8'd0, 8'd9, 4'd0);
    chk("R2 idle tick irq", irq_pulse, 0);
    tick(8'd0, 8'd0, 8'd0, 4'd0);
    chk("R2 idle status", status, 16'h0);

    wr(3'd4, 8'd5);
    wr(3'd0, 8'b101);
    chk("R2 src_en on", tick_src_en, 1);

    foreach (VEC[i]) begin
      tick(8'd0, 8'd0, VEC[i][23:16], VEC[i][15:12]);
      chk($sformatf("R9 vec%0d irq", i), irq_pulse, VEC[i][7:0] != 0);
      chk($sformatf("R6 vec%0d lost", i), lost_pulse, VEC[i][11:8]);
      rd(v);
      chk($sformatf("R3 R5 R7 R10 vec%0d status", i), v,
          {7'b0, (VEC[i][7:0] != 0), VEC[i][7:0]});
    end

    // R4 alarm only
    wr(3'd0, 8'b010);
    wr(3'd1, 8'd56); wr(3'd2, 8'd34); wr(3'd3, 8'd12);
    tick(8'd12, 8'd34, 8'd55, 4'd0);
    chk("R10 no update flag when disabled", status, 16'h0);
    tick(8'd12, 8'd34, 8'd56, 4'd0);
    chk("R4 alarm irq", irq_pulse, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", irq_pulse, 0);
    rd(v);
    chk("R4 alarm status", v, 16'h01A0);
    tick(8'd12, 8'd34, 8'd56, 4'd0);
    chk("R4 no repeat irq", irq_pulse, 0);
    chk("R4 no repeat status", status, 16'h0);

    // R8 sticky and read
    wr(3'd0, 8'b001);
    tick(8'd12, 8'd34, 8'd57, 4'd0);
    chk("R3 update irq", irq_pulse, 1);
    tick(8'd12, 8'd34, 8'd57, 4'd0);
    chk("R3 same sec irq", irq_pulse, 0);
    chk("R8 sticky", status, 16'h0190);
    rd(v);
    chk("R8 read value", v, 16'h0190);
    chk("R8 cleared", status, 16'h0);
    cur_sec = 8'd58; base_tick = 1'b1; stat_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    base_tick = 1'b0; stat_rd = 1'b0;
    chk("R8 set wins over read", status, 16'h0190);
    rd(v);

    // R5 rate exponent 0 -> limit 32
    wr(3'd4, 8'd0);
    wr(3'd0, 8'b100);
    pulses = 0;
    for (int k = 0; k < 31; k++) begin
      tick(8'd0, 8'd0, 8'd0, 4'd0);
      pulses += irq_pulse;
    end
    chk("R5 no early periodic", pulses, 0);
    tick(8'd0, 8'd0, 8'd0, 4'd0);
    chk("R5 periodic at 32", irq_pulse, 1);
    rd(v);
    chk("R5 periodic status", v, 16'h01C0);

    // R5 exponent 7 -> limit 1
    wr(3'd4, 8'd7);
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      tick(8'd0, 8'd0, 8'd0, 4'd0);
      pulses += irq_pulse;
    end
    chk("R5 every tick", pulses, 3);
    rd(v);

    wr(3'd0, 8'd0);
    chk("R2 src_en off", tick_src_en, 0);
    tick(8'd0, 8'd0, 8'd1, 4'd2);
    chk("R2 disabled no irq", irq_pulse, 0);
    chk("R6 lost still raised", lost_pulse, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule